// File: doc/BRIEF.md
# APB transfer capture monitor

A passive observer for an APB-style control bus. It drives nothing on the bus. A transfer starts on a setup edge, where select is high and enable is low. On that edge the monitor latches the address, the direction and the write payload. It then follows the access phase through any wait states. When the completion handshake arrives it emits one transaction record. The record carries the latched setup fields, the read data and the slave-error bit sampled at completion, a cycle timestamp and a fixed instance identifier.

Records leave through a one-entry output register with a valid/ready handshake, so a downstream collector can stall. A completion that arrives while the register is still full is counted as an overflow and that record is dropped.

The bus has its own active-low reset, separate from the monitor's reset. While the bus reset is low the monitor ignores the bus. If the bus reset arrives in the middle of a transfer, the pending capture is dropped and a saturating abort counter is incremented. Sequencing faults on the bus set a sticky protocol-error flag and discard the transfer. The monitor's own reset `rst_ni` clears all state, including the sticky flags and the abort counter.

Top module: `apb_xfer_mon`

## Requirements
- R1: On a setup edge (`psel_i`=1, `penable_i`=0, `bus_rst_ni`=1) the monitor latches `paddr_i`, `pwrite_i` and `pwdata_i`. The record reports these setup values even if `pwdata_i` changes during the access phase.
- R2: A transfer completes only on an edge where `psel_i`, `penable_i` and `pready_i` are all 1. Access edges with `pready_i`=0 are wait states, and no record appears during them.
- R3: For a read (`pwrite_i`=0) the record's read data is `prdata_i` as sampled at the completion edge. For a write the read-data field is zero, whatever `prdata_i` is.
- R4: The record's error bit equals `pslverr_i` as sampled at the completion edge.
- R5: Each completed transfer yields exactly one record. `rec_valid_o` rises in the cycle after the completion edge. The record stays valid and unchanged until an edge with `rec_ready_i`=1 consumes it.
- R6: While `bus_rst_ni`=0 no capture starts and no record is produced. The timestamp is held at zero during this time.
- R7: If `bus_rst_ni` is 0 on an edge while a transfer is pending, the capture is dropped without a record. `abort_cnt_o` then increments, saturating at 2^ACW-1.
- R8: `proto_err_o` sets and stays set until `rst_ni` in three cases, and the transfer produces no record in each:
  - select drops between setup and completion;
  - the address changes between setup and completion;
  - enable is high on an edge with no pending setup.
- R9: `rec_time_o` is the number of edges since both resets were last released, counted up to but not including the completion edge. `rec_id_o` equals the parameter INST_ID.
- R10: A completion while a record is valid and not being consumed sets the sticky `overflow_o` and drops the new record. The held record is kept.
- R11: After `rst_ni` the outputs are `rec_valid_o`=0, `abort_cnt_o`=0, `proto_err_o`=0 and `overflow_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Monitor asynchronous reset, active low |
| bus_rst_ni | input | 1 | Observed bus reset, active low, sampled |
| psel_i | input | 1 | Observed select |
| penable_i | input | 1 | Observed enable |
| pwrite_i | input | 1 | Observed direction, 1 = write |
| paddr_i | input | AW | Observed address |
| pwdata_i | input | DW | Observed write data |
| prdata_i | input | DW | Observed read data |
| pready_i | input | 1 | Observed ready |
| pslverr_i | input | 1 | Observed slave error |
| rec_valid_o | output | 1 | Record valid |
| rec_ready_i | input | 1 | Record consumed by collector |
| rec_addr_o | output | AW | Record address |
| rec_write_o | output | 1 | Record direction |
| rec_wdata_o | output | DW | Record write data |
| rec_rdata_o | output | DW | Record read data (zero for writes) |
| rec_err_o | output | 1 | Record slave error |
| rec_time_o | output | TSW | Record timestamp |
| rec_id_o | output | IDW | Instance identifier |
| abort_cnt_o | output | ACW | Saturating count of reset aborts |
| proto_err_o | output | 1 | Sticky protocol-error flag |
| overflow_o | output | 1 | Sticky output-overflow flag |

## Verification
The hardest case to reach from the ports is a bus reset that lands while a transfer sits in its wait states. It must be told apart from a reset that arrives while the bus is idle. The stimulus drives a setup edge and an access edge with ready low, then pulls the bus reset low for exactly one edge. It then checks that no record appears and that the abort count moved by exactly one. Repeating this sixteen times drives the counter into saturation. Overflow is reached by withholding the collector's ready across a second complete transfer.

// File: rtl/apb_xfer_mon_pkg.sv
package apb_xfer_mon_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_PEND = 1'b1} ph_e;
endpackage

// File: rtl/apb_mon_stamp.sv
module apb_mon_stamp #(
  parameter int TSW = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_rst_ni,
  output logic [TSW-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ts_o <= '0;
    else if (!bus_rst_ni) ts_o <= '0;
    else                  ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/apb_mon_phase.sv
module apb_mon_phase
  import apb_xfer_mon_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int ACW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_rst_ni,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [DW-1:0]  pwdata_i,
  input  logic [DW-1:0]  prdata_i,
  input  logic           pready_i,
  input  logic           pslverr_i,
  output logic           done_o,
  output logic [AW-1:0]  addr_o,
  output logic           write_o,
  output logic [DW-1:0]  wdata_o,
  output logic [DW-1:0]  rdata_o,
  output logic           err_o,
  output logic [ACW-1:0] abort_cnt_o,
  output logic           proto_err_o
);
  localparam logic [ACW-1:0] ABORT_MAX = {ACW{1'b1}};

  ph_e st_q;
  logic addr_ok, setup_edge, access_edge;

  assign addr_ok     = (paddr_i == addr_o);
  assign setup_edge  = psel_i && !penable_i;
  assign access_edge = psel_i && penable_i && addr_ok;

  // completion is combinational so the record takes the timestamp of this edge
  assign done_o  = bus_rst_ni && (st_q == PH_PEND) && access_edge && pready_i;
  assign rdata_o = write_o ? '0 : prdata_i;
  assign err_o   = pslverr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= PH_IDLE;
      addr_o      <= '0;
      write_o     <= 1'b0;
      wdata_o     <= '0;
      abort_cnt_o <= '0;
      proto_err_o <= 1'b0;
    end else if (!bus_rst_ni) begin
      if (st_q == PH_PEND && abort_cnt_o != ABORT_MAX)
        abort_cnt_o <= abort_cnt_o + 1'b1;
      st_q <= PH_IDLE;
    end else begin
      case (st_q)
        PH_IDLE: begin
          if (setup_edge) begin
            addr_o  <= paddr_i;
            write_o <= pwrite_i;
            wdata_o <= pwdata_i;
            st_q    <= PH_PEND;
          end else if (penable_i) begin
            proto_err_o <= 1'b1;
          end
        end
        PH_PEND: begin
          if (!psel_i || !addr_ok) begin
            proto_err_o <= 1'b1;
            st_q        <= PH_IDLE;
          end else if (!penable_i) begin
            // repeated setup: restart capture
            write_o <= pwrite_i;
            wdata_o <= pwdata_i;
          end else if (pready_i) begin
            st_q <= PH_IDLE;
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  AST_ABORT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_cnt_o != $past(abort_cnt_o)) |-> (abort_cnt_o == $past(abort_cnt_o) + 1'b1)); // R7
  AST_ABORT_NEEDS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_ni |=> (abort_cnt_o == $past(abort_cnt_o))); // R7
  AST_PROTO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R8
endmodule

// File: rtl/apb_mon_skid.sv
module apb_mon_skid #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o,
  output logic         overflow_o
);
  logic room;
  assign room = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      overflow_o  <= 1'b0;
    end else begin
      if (in_valid_i && room) begin
        out_valid_o <= 1'b1;
        out_data_o  <= in_data_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
      if (in_valid_i && !room) overflow_o <= 1'b1;
    end
  end

  AST_REC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R5
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R10
endmodule

// File: rtl/apb_xfer_mon.sv
module apb_xfer_mon #(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter int          TSW     = 32,
  parameter int          IDW     = 8,
  parameter int          ACW     = 4,
  parameter logic [7:0]  INST_ID = 8'h5A
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_rst_ni,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [DW-1:0]  pwdata_i,
  input  logic [DW-1:0]  prdata_i,
  input  logic           pready_i,
  input  logic           pslverr_i,
  output logic           rec_valid_o,
  input  logic           rec_ready_i,
  output logic [AW-1:0]  rec_addr_o,
  output logic           rec_write_o,
  output logic [DW-1:0]  rec_wdata_o,
  output logic [DW-1:0]  rec_rdata_o,
  output logic           rec_err_o,
  output logic [TSW-1:0] rec_time_o,
  output logic [IDW-1:0] rec_id_o,
  output logic [ACW-1:0] abort_cnt_o,
  output logic           proto_err_o,
  output logic           overflow_o
);
  localparam int RW = AW + 1 + DW + DW + 1 + TSW;

  logic           done;
  logic [AW-1:0]  c_addr;
  logic           c_write, c_err;
  logic [DW-1:0]  c_wdata, c_rdata;
  logic [TSW-1:0] ts;
  logic [RW-1:0]  rec_in, rec_out;

  apb_mon_stamp #(.TSW(TSW)) u_stamp (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni), .ts_o(ts)
  );

  apb_mon_phase #(.AW(AW), .DW(DW), .ACW(ACW)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_rst_ni(bus_rst_ni),
    .psel_i(psel_i), .penable_i(penable_i), .pwrite_i(pwrite_i),
    .paddr_i(paddr_i), .pwdata_i(pwdata_i), .prdata_i(prdata_i),
    .pready_i(pready_i), .pslverr_i(pslverr_i),
    .done_o(done), .addr_o(c_addr), .write_o(c_write), .wdata_o(c_wdata),
    .rdata_o(c_rdata), .err_o(c_err),
    .abort_cnt_o(abort_cnt_o), .proto_err_o(proto_err_o)
  );

  assign rec_in = {c_addr, c_write, c_wdata, c_rdata, c_err, ts};

  apb_mon_skid #(.W(RW)) u_skid (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_valid_i(done), .in_data_i(rec_in),
    .out_valid_o(rec_valid_o), .out_ready_i(rec_ready_i),
    .out_data_o(rec_out), .overflow_o(overflow_o)
  );

  assign {rec_addr_o, rec_write_o, rec_wdata_o, rec_rdata_o, rec_err_o, rec_time_o} = rec_out;
  assign rec_id_o = IDW'(INST_ID);

  AST_NO_REC_IN_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rst_ni && !rec_valid_o) |=> !rec_valid_o); // R6
  AST_NO_EARLY_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_valid_o && !(psel_i && penable_i && pready_i)) |=> !rec_valid_o); // R2
endmodule

// File: tb/apb_xfer_mon_tb.sv
module apb_xfer_mon_tb;
  localparam int AW = 32, DW = 32, TSW = 32, IDW = 8, ACW = 4;
  localparam logic [7:0] ID = 8'hC3;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        err;
    logic [3:0]  nw;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1000, 32'hDEAD_BEEF, 32'h1111_1111, 1'b0, 4'd0},
    '{1'b0, 32'h0000_1004, 32'h0000_0000, 32'hCAFE_F00D, 1'b0, 4'd0},
    '{1'b1, 32'h0000_2008, 32'h1234_5678, 32'h5555_AAAA, 1'b1, 4'd3},
    '{1'b0, 32'h0000_200C, 32'h0BAD_0BAD, 32'h8765_4321, 1'b1, 4'd2},
    '{1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0001, 1'b0, 4'd5},
    '{1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd1}
  };

  logic clk = 0, rst_n = 0, bus_rst_n = 0;
  logic psel = 0, pen = 0, pwr = 0, prdy = 0, perr = 0, rdy = 0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0, prdata = '0;
  logic rec_valid, rec_write, rec_err, proto_err, overflow;
  logic [AW-1:0] rec_addr;
  logic [DW-1:0] rec_wdata, rec_rdata;
  logic [TSW-1:0] rec_time;
  logic [IDW-1:0] rec_id;
  logic [ACW-1:0] abort_cnt;

  int checks = 0, errors = 0;
  logic [31:0] cyc = 0;

  always #2 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else if (!bus_rst_n) cyc <= 0;
    else cyc <= cyc + 1;

  apb_xfer_mon #(.AW(AW), .DW(DW), .TSW(TSW), .IDW(IDW), .ACW(ACW), .INST_ID(ID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_ni(bus_rst_n),
    .psel_i(psel), .penable_i(pen), .pwrite_i(pwr), .paddr_i(paddr),
    .pwdata_i(pwdata), .prdata_i(prdata), .pready_i(prdy), .pslverr_i(perr),
    .rec_valid_o(rec_valid), .rec_ready_i(rdy), .rec_addr_o(rec_addr),
    .rec_write_o(rec_write), .rec_wdata_o(rec_wdata), .rec_rdata_o(rec_rdata),
    .rec_err_o(rec_err), .rec_time_o(rec_time), .rec_id_o(rec_id),
    .abort_cnt_o(abort_cnt), .proto_err_o(proto_err), .overflow_o(overflow)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    psel = 0; pen = 0; prdy = 0; perr = 0;
  endtask

  task automatic mon_reset();
    @(negedge clk); rst_n = 0; idle_bus(); rdy = 0;
    @(negedge clk); rst_n = 1; bus_rst_n = 1;
  endtask

  // drives a full transfer; returns the timestamp of the completion edge
  task automatic xfer(input vec_t v, input bit chk_wait, output logic [31:0] ts);
    @(negedge clk);
    psel = 1; pen = 0; pwr = v.wr; paddr = v.addr; pwdata = v.wdata; prdata = 32'h7777_7777;
    @(negedge clk);
    pen = 1; pwdata = ~v.wdata; prdy = (v.nw == 0); prdata = v.rdata; perr = v.err;
    if (v.nw != 0) begin
      prdata = ~v.rdata; perr = ~v.err;
      for (int i = 1; i < int'(v.nw); i++) begin
        @(negedge clk);
        if (chk_wait) chk("R2", "no record in wait state", rec_valid, 0);
      end
      @(negedge clk);
      if (chk_wait) chk("R2", "no record in wait state", rec_valid, 0);
      prdy = 1; prdata = v.rdata; perr = v.err;
    end
    ts = cyc;
    @(negedge clk);
    idle_bus();
  endtask

  task automatic chk_rec(input vec_t v, input logic [31:0] ts);
    chk("R5", "valid after completion", rec_valid, 1);
    chk("R1", "addr", rec_addr, v.addr);
    chk("R1", "write", rec_write, v.wr);
    chk("R1", "wdata from setup", rec_wdata, v.wdata);
    chk("R3", "rdata", rec_rdata, v.wr ? 32'h0 : v.rdata);
    chk("R4", "slverr", rec_err, v.err);
    chk("R9", "timestamp", rec_time, ts);
    chk("R9", "instance id", rec_id, ID);
  endtask

  task automatic consume();
    rdy = 1; @(negedge clk); rdy = 0;
    chk("R5", "record consumed once", rec_valid, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] ts, ts2;
    repeat (3) @(negedge clk);
    chk("R11", "valid after reset", rec_valid, 0);
    chk("R11", "abort count after reset", abort_cnt, 0);
    chk("R11", "proto flag after reset", proto_err, 0);
    chk("R11", "overflow after reset", overflow, 0);
    rst_n = 1; bus_rst_n = 1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      xfer(VECS[k], 1'b1, ts);
      chk_rec(VECS[k], ts);
      consume();
    end

    // stall then overflow: R5, R10
    xfer(VECS[2], 1'b1, ts);
    repeat (3) @(negedge clk);
    chk("R5", "held while stalled", rec_valid, 1);
    chk("R5", "held record unchanged", rec_addr, VECS[2].addr);
    xfer(VECS[1], 1'b0, ts2);
    chk("R10", "overflow flag", overflow, 1);
    chk_rec(VECS[2], ts);
    consume();
    chk("R10", "dropped record not emitted", rec_valid, 0);

    // abort mid-transfer: R7
    @(negedge clk);
    psel = 1; pen = 0; pwr = 0; paddr = 32'h40;
    @(negedge clk); pen = 1; prdy = 0;
    @(negedge clk); bus_rst_n = 0;
    @(negedge clk); bus_rst_n = 1; idle_bus();
    @(negedge clk);
    chk("R7", "abort count", abort_cnt, 1);
    chk("R7", "no record on abort", rec_valid, 0);

    // bus ignored during bus reset: R6
    @(negedge clk); bus_rst_n = 0;
    psel = 1; pen = 0; paddr = 32'h80;
    @(negedge clk); pen = 1; prdy = 1;
    @(negedge clk); idle_bus();
    @(negedge clk);
    chk("R6", "no record during bus reset", rec_valid, 0);
    chk("R6", "no abort counted when idle", abort_cnt, 1);
    bus_rst_n = 1;
    xfer(VECS[0], 1'b1, ts);
    chk("R6", "timestamp restarted", (ts < 32'd8) ? 1'b1 : 1'b0, 1);
    chk_rec(VECS[0], ts);
    consume();

    // saturation: R7
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); psel = 1; pen = 0; paddr = 32'h44;
      @(negedge clk); pen = 1; prdy = 0;
      @(negedge clk); bus_rst_n = 0;
      @(negedge clk); bus_rst_n = 1; idle_bus();
    end
    @(negedge clk);
    chk("R7", "abort count saturates", abort_cnt, 15);

    // protocol faults: R8
    mon_reset();
    @(negedge clk); psel = 1; pen = 1; paddr = 32'h10;
    @(negedge clk); idle_bus();
    @(negedge clk);
    chk("R8", "enable without setup", proto_err, 1);
    chk("R8", "no record", rec_valid, 0);
    repeat (2) @(negedge clk);
    chk("R8", "flag sticky", proto_err, 1);

    mon_reset();
    @(negedge clk); psel = 1; pen = 0; paddr = 32'h20;
    @(negedge clk); psel = 0;
    @(negedge clk); pen = 1; prdy = 1;
    @(negedge clk); idle_bus();
    chk("R8", "select drop", proto_err, 1);
    chk("R8", "no record after select drop", rec_valid, 0);

    mon_reset();
    @(negedge clk); psel = 1; pen = 0; paddr = 32'h30;
    @(negedge clk); pen = 1; prdy = 0;
    @(negedge clk); paddr = 32'h34; prdy = 1;
    @(negedge clk); idle_bus();
    @(negedge clk);
    chk("R8", "address change", proto_err, 1);
    chk("R8", "no record after address change", rec_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule